// File: doc/BRIEF.md
# Output Test Pattern Selector

This block decides which word the serial output formatter sends in each frame. It can pass through live converter samples, or it can replace them with one of twelve test patterns. The test patterns help a receiver check that it captures the serial stream correctly and with the right timing. Some patterns are fixed words. Some alternate between two words on successive frames. One pattern replays two words that software loads into four byte-wide user registers. Two pseudorandom patterns take their words from an external generator.

The selector also scales each pattern to the programmed word length, from 8 to 14 bits. It reports the word length that actually applies, which is fixed at 12 bits for the pseudorandom modes. It raises a flag for the patterns that must skip the downstream data-format conversion.

The formatter marks the start of each frame with a one-cycle `frame_i` strobe. On that clock edge the selector registers the word, the length and the flag for the new frame.

Top module: `test_pattern_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `word_o`, `len_o` and `bypass_o` become 0 after that edge. The first frame after reset uses the first word of any alternating pattern.
- R2: `word_o`, `len_o` and `bypass_o` change only after a clock edge at which `frame_i` is high. At all other edges they hold their values, whatever the other inputs do.
- R3: Mode code 0 gives live data: `word_o` is `adc_i` masked to its low L bits, `len_o` is L and `bypass_o` is 0. Unused codes 13, 14 and 15 behave the same as code 0.
- R4: The effective length L is `wlen_i` limited to the range 8..14. A value below 8 is used as 8 and a value above 14 is used as 14. `len_o` reports L for every mode except 11 and 12.
- R5: The fixed patterns are right-aligned in L bits and defined as follows, where "top L bits of X" means X >> (14-L):
  - code 1 (midscale): 1 << (L-1)
  - code 2 (positive full scale): all L bits set
  - code 3 (negative full scale): 0
  - code 7 (sync): (1 << (L/2)) - 1
  - code 8 (one bit high): 1
  - code 9 (mixed frequency): top L bits of 14'h2492
- R6: The alternating patterns give word A in the first frame and word B in the next:
  - code 4: A is the top L bits of 14'h2AAA, and B is the bitwise complement of A within L bits
  - code 5: A has all L bits set, and B is 0
  - code 6: A is 0, and B has all L bits set
- R7: The alternation phase restarts at word A in any frame whose mode code differs from the code used in the previous frame. It then toggles every frame while the code stays the same.
- R8: Code 10 alternates two user words, each masked to L bits. Word A is {reg1, reg0} and word B is {reg3, reg2}. Register n is written with `uw_data_i` when `uw_en_i` is high and `uw_addr_i` equals n.
- R9: A user register write changes only the words of later frames. A write in the same cycle as `frame_i` does not affect the frame loaded at that edge.
- R10: Code 11 outputs `pn_short_i` and code 12 outputs `pn_long_i`, zero-extended. For both codes `len_o` is 12, whatever `wlen_i` is.
- R11: `bypass_o` is 1 exactly for codes 10, 11 and 12, and 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Pattern mode code |
| wlen_i | input | 4 | Programmed word length |
| frame_i | input | 1 | Frame boundary strobe, one cycle |
| adc_i | input | 14 | Live converter sample |
| pn_short_i | input | 12 | Word from the short pseudorandom generator |
| pn_long_i | input | 12 | Word from the long pseudorandom generator |
| uw_en_i | input | 1 | User register write enable |
| uw_addr_i | input | 2 | User register index |
| uw_data_i | input | 8 | User register write data |
| word_o | output | 14 | Word for the current frame, right-aligned |
| len_o | output | 4 | Effective word length for the current frame |
| bypass_o | output | 1 | High when the word must skip format conversion |

## Verification
The bench tests all mode codes, and each one shows a different aspect of the selector:
- Live data runs at two word lengths, and with an unused code, so masking and the fallback path are both exercised.
- Word lengths of 3 and 15 check the clamping at both ends of the range.
- The fixed patterns run at lengths 10 and 14 to show right-alignment.
- The alternating patterns run for several frames in a row, then the mode switches mid-run, so a lost phase reset or a wrong word order shows up.
- User register writes are placed between frames and also on a frame edge, which separates immediate, deferred and dropped updates.
- Pseudorandom words are sent at a short programmed length, to show that the 12-bit length and the bypass flag are forced.

// File: rtl/tps_pkg.sv
// Shared mode codes and per-mode properties for the test pattern selector.
// Assumes a 4-bit mode code; codes above the last defined one act as live data.
package tps_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_LIVE     = 4'd0,
        MODE_MID      = 4'd1,
        MODE_PFS      = 4'd2,
        MODE_NFS      = 4'd3,
        MODE_CHECKER  = 4'd4,
        MODE_ONEZERO  = 4'd5,
        MODE_ZEROONE  = 4'd6,
        MODE_SYNC     = 4'd7,
        MODE_ONEBIT   = 4'd8,
        MODE_MIXED    = 4'd9,
        MODE_USER     = 4'd10,
        MODE_PN_SHORT = 4'd11,
        MODE_PN_LONG  = 4'd12
    } tp_mode_e;

    // Modes whose words must not pass through data-format conversion.
    function automatic logic mode_bypasses(input logic [MODE_W-1:0] m);
        return (m == MODE_USER) || (m == MODE_PN_SHORT) || (m == MODE_PN_LONG);
    endfunction

endpackage

// File: rtl/tps_user_regs.sv
// Holds the byte-wide user pattern registers.
// Assumes one write port; a write lands on the clock edge where uw_en_i is high.
module tps_user_regs #(
    parameter int UREG_W = 8,
    parameter int N_UREG = 4,
    localparam int UADDR_W = $clog2(N_UREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           uw_en_i,
    input  logic [UADDR_W-1:0]             uw_addr_i,
    input  logic [UREG_W-1:0]              uw_data_i,
    output logic [N_UREG-1:0][UREG_W-1:0]  regs_o
);

    for (genvar g = 0; g < N_UREG; g++) begin : g_reg
        // Load register g when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_o[g] <= '0;
            end else if (uw_en_i && (uw_addr_i == UADDR_W'(g))) begin
                regs_o[g] <= uw_data_i;
            end
        end
    end

endmodule

// File: rtl/tps_phase.sv
// Tracks which word of a two-word pattern the current frame uses.
// Assumes frame_i is a one-cycle strobe; the phase restarts when the mode
// differs from the mode used in the previous frame.
module tps_phase #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              phase_o
);

    logic              phase_q;
    logic [MODE_W-1:0] mode_q;

    // Phase for the frame starting now: first word on any mode change.
    always_comb begin
        phase_o = (mode_i != mode_q) ? 1'b0 : phase_q;
    end

    // Remember the mode and advance the phase at every frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            mode_q  <= '0;
        end else if (frame_i) begin
            phase_q <= ~phase_o;
            mode_q  <= mode_i;
        end
    end

endmodule

// File: rtl/tps_pattern.sv
// Combinational word generator: builds the word, effective length and
// bypass flag for one frame from mode, length, phase and sources.
// Assumes 2*UREG_W >= DATA_W and PN_W < DATA_W.
module tps_pattern
    import tps_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int MIN_LEN = 8,
    parameter int PN_W    = 12,
    parameter int UREG_W  = 8,
    localparam int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [LEN_W-1:0]    wlen_i,
    input  logic                phase_i,
    input  logic [DATA_W-1:0]   adc_i,
    input  logic [PN_W-1:0]     pn_short_i,
    input  logic [PN_W-1:0]     pn_long_i,
    input  logic [2*UREG_W-1:0] user_a_i,
    input  logic [2*UREG_W-1:0] user_b_i,
    output logic [DATA_W-1:0]   word_o,
    output logic [LEN_W-1:0]    len_o,
    output logic                bypass_o
);

    // MSB-first word with a one every 'period' bits starting at the MSB.
    function automatic logic [DATA_W-1:0] msb_period(input int period);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int k = 0; k < DATA_W; k++) begin
            v[DATA_W-1-k] = ((k % period) == 0);
        end
        return v;
    endfunction

    localparam logic [DATA_W-1:0] ONES     = '1;
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);
    localparam logic [DATA_W-1:0] CHK_FULL = msb_period(2);
    localparam logic [DATA_W-1:0] MIX_FULL = msb_period(3);
    localparam logic [DATA_W-PN_W-1:0] PN_PAD = '0;

    logic [LEN_W-1:0]  eff_len;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] chk_word;
    int                drop;

    // Clamp the programmed length and derive the mask and shift amount.
    always_comb begin
        if (wlen_i < LEN_W'(MIN_LEN)) begin
            eff_len = LEN_W'(MIN_LEN);
        end else if (wlen_i > LEN_W'(DATA_W)) begin
            eff_len = LEN_W'(DATA_W);
        end else begin
            eff_len = wlen_i;
        end
        drop     = DATA_W - int'(eff_len);
        mask     = ONES >> drop;
        chk_word = CHK_FULL >> drop;
    end

    // Pick the word for this frame according to mode and phase.
    always_comb begin
        len_o    = eff_len;
        bypass_o = mode_bypasses(mode_i);
        case (mode_i)
            MODE_MID:      word_o = ONE << (int'(eff_len) - 1);
            MODE_PFS:      word_o = mask;
            MODE_NFS:      word_o = '0;
            MODE_CHECKER:  word_o = phase_i ? (~chk_word & mask) : chk_word;
            MODE_ONEZERO:  word_o = phase_i ? '0 : mask;
            MODE_ZEROONE:  word_o = phase_i ? mask : '0;
            MODE_SYNC:     word_o = ONES >> (DATA_W - int'(eff_len) / 2);
            MODE_ONEBIT:   word_o = ONE;
            MODE_MIXED:    word_o = MIX_FULL >> drop;
            MODE_USER:     word_o = (phase_i ? DATA_W'(user_b_i) : DATA_W'(user_a_i)) & mask;
            MODE_PN_SHORT: begin
                word_o = {PN_PAD, pn_short_i};
                len_o  = LEN_W'(PN_W);
            end
            MODE_PN_LONG:  begin
                word_o = {PN_PAD, pn_long_i};
                len_o  = LEN_W'(PN_W);
            end
            default:       word_o = adc_i & mask;
        endcase
    end

endmodule

// File: rtl/test_pattern_sel.sv
// Output test pattern selector top. Registers word, length and bypass flag
// at each frame strobe and holds them in between.
// Assumes frame_i is a one-cycle strobe from the serial formatter.
module test_pattern_sel
    import tps_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int MIN_LEN = 8,
    parameter int PN_W    = 12,
    parameter int UREG_W  = 8,
    parameter int N_UREG  = 4,
    localparam int LEN_W   = $clog2(DATA_W + 1),
    localparam int UADDR_W = $clog2(N_UREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [LEN_W-1:0]   wlen_i,
    input  logic               frame_i,
    input  logic [DATA_W-1:0]  adc_i,
    input  logic [PN_W-1:0]    pn_short_i,
    input  logic [PN_W-1:0]    pn_long_i,
    input  logic               uw_en_i,
    input  logic [UADDR_W-1:0] uw_addr_i,
    input  logic [UREG_W-1:0]  uw_data_i,
    output logic [DATA_W-1:0]  word_o,
    output logic [LEN_W-1:0]   len_o,
    output logic               bypass_o
);

    logic [N_UREG-1:0][UREG_W-1:0] uregs;
    logic                          phase;
    logic [DATA_W-1:0]             word_nxt;
    logic [LEN_W-1:0]              len_nxt;
    logic                          byp_nxt;

    tps_user_regs #(
        .UREG_W(UREG_W),
        .N_UREG(N_UREG)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .uw_en_i  (uw_en_i),
        .uw_addr_i(uw_addr_i),
        .uw_data_i(uw_data_i),
        .regs_o   (uregs)
    );

    tps_phase #(
        .MODE_W(MODE_W)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .frame_i(frame_i),
        .mode_i (mode_i),
        .phase_o(phase)
    );

    tps_pattern #(
        .DATA_W (DATA_W),
        .MIN_LEN(MIN_LEN),
        .PN_W   (PN_W),
        .UREG_W (UREG_W)
    ) u_pattern (
        .mode_i    (mode_i),
        .wlen_i    (wlen_i),
        .phase_i   (phase),
        .adc_i     (adc_i),
        .pn_short_i(pn_short_i),
        .pn_long_i (pn_long_i),
        .user_a_i  ({uregs[1], uregs[0]}),
        .user_b_i  ({uregs[3], uregs[2]}),
        .word_o    (word_nxt),
        .len_o     (len_nxt),
        .bypass_o  (byp_nxt)
    );

    // Capture the frame's word, length and bypass flag at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o   <= '0;
            len_o    <= '0;
            bypass_o <= 1'b0;
        end else if (frame_i) begin
            word_o   <= word_nxt;
            len_o    <= len_nxt;
            bypass_o <= byp_nxt;
        end
    end

endmodule

// File: rtl/tps_checker.sv
// Protocol checks for the test pattern selector, bound into its top.
// Assumes the default mode code assignment of tps_pkg.
module tps_checker #(
    parameter int DATA_W  = 14,
    parameter int MIN_LEN = 8,
    parameter int PN_W    = 12,
    parameter int LEN_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_i,
    input logic [3:0]        mode_i,
    input logic [DATA_W-1:0] word_o,
    input logic [LEN_W-1:0]  len_o,
    input logic              bypass_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (word_o == '0 && len_o == '0 && !bypass_o)); // R1

    AST_HOLD_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> ($stable(word_o) && $stable(len_o) && $stable(bypass_o))); // R2

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (len_o >= LEN_W'(MIN_LEN) && len_o <= LEN_W'(DATA_W))); // R4

    AST_NFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && mode_i == 4'd3) |=> (word_o == '0)); // R5

    AST_PN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && (mode_i == 4'd11 || mode_i == 4'd12)) |=> (len_o == LEN_W'(PN_W))); // R10

    AST_BYPASS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && (mode_i == 4'd10 || mode_i == 4'd11 || mode_i == 4'd12)) |=> bypass_o); // R11

    AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && (mode_i < 4'd10 || mode_i > 4'd12)) |=> !bypass_o); // R11

endmodule

bind test_pattern_sel tps_checker #(
    .DATA_W (DATA_W),
    .MIN_LEN(MIN_LEN),
    .PN_W   (PN_W),
    .LEN_W  (LEN_W)
) u_tps_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame_i),
    .mode_i  (mode_i),
    .word_o  (word_o),
    .len_o   (len_o),
    .bypass_o(bypass_o)
);

// File: tb/test_test_pattern_sel.sv
// Scoreboard bench: the driver pushes expected frame results into a queue,
// and the monitor pops and compares them one cycle after each frame edge.
module test_test_pattern_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [3:0]  wlen_i = 4'd12;
    logic        frame_i = 1'b0;
    logic [13:0] adc_i = '0;
    logic [11:0] pn_short_i = '0;
    logic [11:0] pn_long_i = '0;
    logic        uw_en_i = 1'b0;
    logic [1:0]  uw_addr_i = '0;
    logic [7:0]  uw_data_i = '0;
    logic [13:0] word_o;
    logic [3:0]  len_o;
    logic        bypass_o;

    test_pattern_sel i_test_pattern_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .wlen_i    (wlen_i),
        .frame_i   (frame_i),
        .adc_i     (adc_i),
        .pn_short_i(pn_short_i),
        .pn_long_i (pn_long_i),
        .uw_en_i   (uw_en_i),
        .uw_addr_i (uw_addr_i),
        .uw_data_i (uw_data_i),
        .word_o    (word_o),
        .len_o     (len_o),
        .bypass_o  (bypass_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [13:0] w;
        int          l;
        bit          b;
        string       r;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;

    // Bench-side model of the requirements.
    logic [7:0]  ureg [4];
    int          prev_mode = 0;
    bit          ph_next = 0;
    logic [13:0] last_w;
    int          last_l;
    bit          last_b;

    task automatic check(input string req, input logic [13:0] aw, input int al, input bit ab,
                         input logic [13:0] ew, input int el, input bit eb);
        total++;
        if (aw !== ew || al != el || ab !== eb) begin
            bad++;
            $display("FAIL %s: word=%h len=%0d byp=%0b expected word=%h len=%0d byp=%0b",
                     req, aw, al, ab, ew, el, eb);
        end
    endtask

    function automatic exp_t expect_frame(input int m, input int wl, input logic [13:0] adc,
                                          input logic [11:0] pns, input logic [11:0] pnl,
                                          input string req);
        exp_t e;
        int   L;
        bit   ph;
        logic [13:0] msk, chk;
        L   = (wl < 8) ? 8 : ((wl > 14) ? 14 : wl);
        msk = 14'((1 << L) - 1);
        chk = 14'(14'h2AAA >> (14 - L));
        ph  = (m != prev_mode) ? 1'b0 : ph_next;
        prev_mode = m;
        ph_next   = !ph;
        e.l = L;
        e.b = (m >= 10 && m <= 12);
        e.r = req;
        case (m)
            1:  e.w = 14'(1 << (L - 1));
            2:  e.w = msk;
            3:  e.w = '0;
            4:  e.w = ph ? (~chk & msk) : chk;
            5:  e.w = ph ? 14'h0 : msk;
            6:  e.w = ph ? msk : 14'h0;
            7:  e.w = 14'((1 << (L / 2)) - 1);
            8:  e.w = 14'd1;
            9:  e.w = 14'(14'h2492 >> (14 - L));
            10: e.w = (ph ? 14'({ureg[3], ureg[2]}) : 14'({ureg[1], ureg[0]})) & msk;
            11: begin e.w = {2'b00, pns}; e.l = 12; end
            12: begin e.w = {2'b00, pnl}; e.l = 12; end
            default: e.w = adc & msk;
        endcase
        return e;
    endfunction

    // Driver: one frame strobe, optionally with a coincident user write.
    task automatic do_frame(input int m, input int wl, input logic [13:0] adc,
                            input logic [11:0] pns, input logic [11:0] pnl, input string req,
                            input bit wr = 0, input int wa = 0, input logic [7:0] wd = 0);
        exp_t e;
        @(negedge clk);
        mode_i = 4'(m); wlen_i = 4'(wl); adc_i = adc;
        pn_short_i = pns; pn_long_i = pnl;
        frame_i = 1'b1;
        uw_en_i = wr; uw_addr_i = 2'(wa); uw_data_i = wd;
        e = expect_frame(m, wl, adc, pns, pnl, req);
        if (wr) ureg[wa] = wd;
        q.push_back(e);
        last_w = e.w; last_l = e.l; last_b = e.b;
        @(negedge clk);
        frame_i = 1'b0;
        uw_en_i = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        uw_en_i = 1'b1; uw_addr_i = 2'(a); uw_data_i = d;
        ureg[a] = d;
        @(negedge clk);
        uw_en_i = 1'b0;
    endtask

    // Monitor: compare outputs one half cycle after each frame edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (rst_n && frame_i) begin
                @(negedge clk);
                if (q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL scoreboard: unexpected frame, queue empty");
                end else begin
                    e = q.pop_front();
                    check(e.r, word_o, int'(len_o), bypass_o, e.w, e.l, e.b);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) ureg[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: outputs cleared by reset.
        check("R1 reset", word_o, int'(len_o), bypass_o, 14'h0, 0, 1'b0);
        rst_n = 1'b1;

        // R3: live data masking and unused codes.
        do_frame(0, 12, 14'h3ABC, 12'h0, 12'h0, "R3 live L12");
        do_frame(0, 14, 14'h3ABC, 12'h0, 12'h0, "R3 live L14");
        do_frame(13, 12, 14'h1234, 12'h0, 12'h0, "R3 code13 as live");
        do_frame(15, 9, 14'h3FFF, 12'h0, 12'h0, "R3 code15 as live");

        // R4: length clamping at both ends.
        do_frame(2, 3, 14'h0, 12'h0, 12'h0, "R4 clamp low");
        do_frame(2, 15, 14'h0, 12'h0, 12'h0, "R4 clamp high");

        // R5: fixed patterns at two lengths.
        for (int L = 10; L <= 14; L += 4) begin
            do_frame(1, L, 14'h0, 12'h0, 12'h0, "R5 midscale");
            do_frame(3, L, 14'h0, 12'h0, 12'h0, "R5 negative full scale");
            do_frame(7, L, 14'h0, 12'h0, 12'h0, "R5 sync");
            do_frame(8, L, 14'h0, 12'h0, 12'h0, "R5 one bit high");
            do_frame(9, L, 14'h0, 12'h0, 12'h0, "R5 mixed");
        end

        // R6, R7: alternating patterns and phase restart.
        do_frame(4, 12, 14'h0, 12'h0, 12'h0, "R6 checker A");
        do_frame(4, 12, 14'h0, 12'h0, 12'h0, "R6 checker B");
        do_frame(4, 12, 14'h0, 12'h0, 12'h0, "R7 checker A again");
        do_frame(5, 12, 14'h0, 12'h0, 12'h0, "R7 onezero restart A");
        do_frame(5, 12, 14'h0, 12'h0, 12'h0, "R6 onezero B");
        do_frame(6, 8, 14'h0, 12'h0, 12'h0, "R7 zeroone restart A");
        do_frame(6, 8, 14'h0, 12'h0, 12'h0, "R6 zeroone B");
        do_frame(4, 14, 14'h0, 12'h0, 12'h0, "R7 checker restart after switch");

        // R2: outputs hold without a frame strobe.
        @(negedge clk);
        mode_i = 4'd2; wlen_i = 4'd14; adc_i = 14'h1555;
        repeat (3) @(negedge clk);
        check("R2 hold", word_o, int'(len_o), bypass_o, last_w, last_l, last_b);

        // R8: user words.
        do_write(0, 8'h5A);
        do_write(1, 8'hC3);
        do_write(2, 8'h0F);
        do_write(3, 8'hF1);
        do_frame(10, 14, 14'h0, 12'h0, 12'h0, "R8 user A");
        do_frame(10, 14, 14'h0, 12'h0, 12'h0, "R8 user B");
        do_frame(10, 10, 14'h0, 12'h0, 12'h0, "R8 user A masked");

        // R9: write between frames is seen at the next frame; write on a
        // frame edge is not used by that frame.
        do_write(2, 8'hA5);
        do_frame(10, 14, 14'h0, 12'h0, 12'h0, "R9 user B after write");
        do_frame(10, 14, 14'h0, 12'h0, 12'h0, "R9 coincident write ignored", 1'b1, 0, 8'h33);
        do_frame(10, 14, 14'h0, 12'h0, 12'h0, "R9 user B next");
        do_frame(10, 14, 14'h0, 12'h0, 12'h0, "R9 coincident write now seen");

        // R10, R11: pseudorandom words with fixed length and bypass.
        do_frame(11, 8, 14'h0, 12'hDF9, 12'h591, "R10 pn short");
        do_frame(12, 14, 14'h0, 12'h353, 12'hFD7, "R10 pn long");
        do_frame(9, 12, 14'h0, 12'h0, 12'h0, "R11 bypass cleared");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule